// File: doc/BRIEF.md
# Preamble-Locked Bit Synchronizer and Character Assembler

This block sits behind a two-tone detector that hands over one hard decision (mark or space) per audio sample. A transmitted bit spans a fixed number of those decisions, twelve by default. A small phase counter follows the decision stream and moves its phase toward the observed bit edges. The block takes each bit at the counter's mid-bit phase.

The recovered bits go into a shift register, least significant bit first. The block looks for a known byte that the sender repeats at the start of every message, by default 0xAB. When that byte has been seen the required number of times in a row, exactly one byte length apart, the block declares lock. From then on it slices the bit stream into byte-aligned characters. Further sync bytes are skipped, and printable 7-bit characters are offered on a valid/ready port to a serial transmitter.

A character with its top bit set, other than the sync byte, is read as loss of the message. The block then drops lock and hunts for the preamble again. A single holding register absorbs a stalled consumer. When a character completes while that register is still occupied, the new character is lost and a sticky overflow flag is raised.

Top module: `afsk_bit_sync`

## Requirements
- R1: A phase counter advances by one, modulo SAMPLES_PER_BIT (12), on every cycle with `dec_valid` high and holds otherwise. The decision presented while the counter reads CENTRE_PHASE (6) is taken as the bit value.
- R2: When a valid decision differs from the previous valid decision, the counter is corrected by one step toward zero instead of its normal advance. If the phase is below half a bit, the counter holds. If the phase is at or above half a bit, it advances by two, modulo the bit length. This keeps bits decoded correctly when the sender's bit length drifts by about 2 percent.
- R3: Bits enter an 8-bit shift register at the top, so the first bit received ends up as bit 0. `locked` rises only after the register has equalled 0xAB twice, with the two matches exactly 8 bits apart. A lone 0xAB followed by other bytes leaves `locked` low.
- R4: While locked, every eighth bit counted from the lock point completes a byte. A completed byte equal to 0xAB is discarded, and lock is kept.
- R5: While locked, a completed byte with bit 7 clear is delivered as a character. A completed byte with bit 7 set that is not 0xAB clears `locked` and is not delivered. While unlocked, no character is produced.
- R6: `char_valid` stays high, with `char_data` unchanged, until a cycle in which `char_ready` is high. It falls after that cycle unless a new character arrives.
- R7: A character that completes while `char_valid` is high and `char_ready` is low is dropped, and `overflow` is set. `overflow` stays set until reset.
- R8: After reset, `locked`, `char_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_bit | input | 1 | Tone decision: 1 = mark, 0 = space |
| dec_valid | input | 1 | Strobe marking a new decision sample |
| char_ready | input | 1 | Consumer accepts the offered character |
| locked | output | 1 | Preamble found and byte framing established |
| char_data | output | 8 | Offered character |
| char_valid | output | 1 | Character on `char_data` is pending |
| overflow | output | 1 | Sticky: a character was lost to a full holding register |

## Verification
The bench builds the block with its defaults: twelve decisions per bit, mid-bit phase 6, sync byte 0xAB, two matches for lock, and edge nudging rather than snapping. The stream opens several samples off the bit grid, which places the first bit edges away from phase zero. One run stretches every fourth bit by a sample, which the block can only follow through the one-step phase correction. With two sync repeats, a single stray sync byte is enough to tell a lock from a false lock. The stalled-consumer run fills the single holding register and then overruns it.

// File: rtl/afsk_sync_pkg.sv
package afsk_sync_pkg;
   typedef enum logic {
      SYNC_HUNT = 1'b0,
      SYNC_HELD = 1'b1
   } sync_state_t;
endpackage

// File: rtl/bit_phase_track.sv
// Tracks the bit grid in the decision stream and emits one strobe per bit.
module bit_phase_track #(
   parameter int SPB         = 12,
   parameter int CENTRE      = SPB / 2,
   parameter bit HARD_RESYNC = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic                   smp_bit,
   output logic                   bit_stb,
   output logic                   bit_val,
   output logic [$clog2(SPB)-1:0] phase
);
   localparam int PW   = $clog2(SPB);
   localparam int HALF = SPB / 2;

   logic          prev_bit;
   logic          edge_seen;
   logic [PW-1:0] ph_inc;
   logic [PW-1:0] ph_fix;
   logic [PW-1:0] ph_nx;

   assign edge_seen = (smp_bit != prev_bit);
   assign ph_inc    = (phase == PW'(SPB - 1)) ? '0 : phase + 1'b1;

   generate
      if (HARD_RESYNC) begin : g_snap
         // edge sample becomes phase zero, so the next one reads one
         assign ph_fix = PW'(1);
      end else begin : g_nudge
         always_comb begin
            int t;
            t = int'(phase) + 2;
            if (t >= SPB) t = t - SPB;
            if (phase == '0)
               ph_fix = ph_inc;
            else if (int'(phase) < HALF)
               ph_fix = phase;
            else
               ph_fix = PW'(t);
         end
      end
   endgenerate

   assign ph_nx = edge_seen ? ph_fix : ph_inc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= '0;
         prev_bit <= 1'b0;
         bit_stb  <= 1'b0;
         bit_val  <= 1'b0;
      end else begin
         bit_stb <= 1'b0;
         if (smp_valid) begin
            phase    <= ph_nx;
            prev_bit <= smp_bit;
            if (phase == PW'(CENTRE)) begin
               bit_stb <= 1'b1;
               bit_val <= smp_bit;
            end
         end
      end
   end
endmodule

// File: rtl/sync_framer.sv
// Hunts for the repeated sync byte, then frames bytes after lock.
module sync_framer
   import afsk_sync_pkg::*;
#(
   parameter int         W        = 8,
   parameter logic [7:0] SYNC     = 8'hAB,
   parameter int         REPEATS  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_stb,
   input  logic         bit_val,
   output logic         locked,
   output logic         byte_stb,
   output logic [W-1:0] byte_val
);
   localparam int CW = $clog2(W);
   localparam int MW = $clog2(REPEATS + 1);

   sync_state_t   state;
   logic [W-1:0]  shreg;
   logic [W-1:0]  shreg_nx;
   logic [CW-1:0] bcnt;
   logic [MW-1:0] mcnt;
   logic [MW-1:0] mcnt_nx;
   logic          is_sync;
   logic          chained;
   logic          bcnt_full;

   assign shreg_nx  = {bit_val, shreg[W-1:1]};
   assign is_sync   = (shreg_nx == W'(SYNC));
   assign bcnt_full = (bcnt == CW'(W - 1));
   assign chained   = (mcnt != '0) && bcnt_full;
   assign mcnt_nx   = chained ? mcnt + 1'b1 : MW'(1);
   assign locked    = (state == SYNC_HELD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SYNC_HUNT;
         shreg    <= '0;
         bcnt     <= '0;
         mcnt     <= '0;
         byte_stb <= 1'b0;
         byte_val <= '0;
      end else begin
         byte_stb <= 1'b0;
         if (bit_stb) begin
            shreg <= shreg_nx;
            unique case (state)
               SYNC_HUNT: begin
                  if (is_sync) begin
                     bcnt <= '0;
                     if (int'(mcnt_nx) >= REPEATS) begin
                        state <= SYNC_HELD;
                        mcnt  <= '0;
                     end else begin
                        mcnt <= mcnt_nx;
                     end
                  end else begin
                     if (bcnt_full) mcnt <= '0;
                     else           bcnt <= bcnt + 1'b1;
                  end
               end
               SYNC_HELD: begin
                  if (bcnt_full) begin
                     bcnt <= '0;
                     if (!is_sync) begin
                        if (shreg_nx[W-1]) begin
                           state <= SYNC_HUNT;
                        end else begin
                           byte_stb <= 1'b1;
                           byte_val <= shreg_nx;
                        end
                     end
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               default: state <= SYNC_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/char_hold.sv
// One-entry holding register toward the consumer, with sticky overflow.
module char_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_stb,
   input  logic [W-1:0] in_data,
   input  logic         out_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         overflow
);
   logic slot_free;
   assign slot_free = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         overflow  <= 1'b0;
      end else if (in_stb) begin
         if (slot_free) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
         end else begin
            overflow <= 1'b1;
         end
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/afsk_bit_sync.sv
module afsk_bit_sync #(
   parameter int         SAMPLES_PER_BIT = 12,
   parameter int         CENTRE_PHASE    = SAMPLES_PER_BIT / 2,
   parameter int         CHAR_W          = 8,
   parameter logic [7:0] SYNC_PATTERN    = 8'hAB,
   parameter int         SYNC_REPEATS    = 2,
   parameter bit         HARD_RESYNC     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_bit,
   input  logic              dec_valid,
   input  logic              char_ready,
   output logic              locked,
   output logic [CHAR_W-1:0] char_data,
   output logic              char_valid,
   output logic              overflow
);
   localparam int PW = $clog2(SAMPLES_PER_BIT);

   if (SAMPLES_PER_BIT < 4) begin : g_bad_spb
      $error("SAMPLES_PER_BIT must be at least 4");
   end
   if (CENTRE_PHASE < 1 || CENTRE_PHASE >= SAMPLES_PER_BIT) begin : g_bad_ctr
      $error("CENTRE_PHASE must lie inside the bit");
   end
   if (CHAR_W != 8) begin : g_bad_w
      $error("CHAR_W must be 8 to match the sync pattern");
   end
   if (SYNC_REPEATS < 1) begin : g_bad_rep
      $error("SYNC_REPEATS must be at least 1");
   end

   logic              bit_stb;
   logic              bit_val;
   logic [PW-1:0]     phase;
   logic              byte_stb;
   logic [CHAR_W-1:0] byte_val;

   bit_phase_track #(
      .SPB         (SAMPLES_PER_BIT),
      .CENTRE      (CENTRE_PHASE),
      .HARD_RESYNC (HARD_RESYNC)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (dec_valid),
      .smp_bit   (dec_bit),
      .bit_stb   (bit_stb),
      .bit_val   (bit_val),
      .phase     (phase)
   );

   sync_framer #(
      .W       (CHAR_W),
      .SYNC    (SYNC_PATTERN),
      .REPEATS (SYNC_REPEATS)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb  (bit_stb),
      .bit_val  (bit_val),
      .locked   (locked),
      .byte_stb (byte_stb),
      .byte_val (byte_val)
   );

   char_hold #(
      .W (CHAR_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_stb    (byte_stb),
      .in_data   (byte_val),
      .out_ready (char_ready),
      .out_valid (char_valid),
      .out_data  (char_data),
      .overflow  (overflow)
   );
endmodule

// File: rtl/afsk_bit_sync_chk.sv
module afsk_bit_sync_chk #(
   parameter int SPB = 12,
   parameter int W   = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   dec_valid,
   input logic [$clog2(SPB)-1:0] phase,
   input logic                   locked,
   input logic                   char_valid,
   input logic                   char_ready,
   input logic [W-1:0]           char_data,
   input logic                   overflow
);
   assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(phase) < SPB);

   assert_phase_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> $stable(phase));

   assert_char_only_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(char_valid) |-> locked);

   assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !char_ready) |=> (char_valid && $stable(char_data)));

   assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

bind afsk_bit_sync afsk_bit_sync_chk #(
   .SPB (SAMPLES_PER_BIT),
   .W   (CHAR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_valid  (dec_valid),
   .phase      (phase),
   .locked     (locked),
   .char_valid (char_valid),
   .char_ready (char_ready),
   .char_data  (char_data),
   .overflow   (overflow)
);

// File: tb/tb_afsk_bit_sync.sv
module tb_afsk_bit_sync;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_bit = 1'b0;
   logic       dec_valid = 1'b0;
   logic       char_ready = 1'b1;
   logic       locked;
   logic [7:0] char_data;
   logic       char_valid;
   logic       overflow;

   int checks = 0;
   int fails  = 0;
   int rx_cnt = 0;
   logic [7:0] rx_last = 8'h00;
   int cyc = 0;
   int stretch_every = 0;   // 0: all bits 12 samples
   int bit_no = 0;

   always #10 clk = ~clk;

   afsk_bit_sync dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_bit    (dec_bit),
      .dec_valid  (dec_valid),
      .char_ready (char_ready),
      .locked     (locked),
      .char_data  (char_data),
      .char_valid (char_valid),
      .overflow   (overflow)
   );

   always @(negedge clk) begin
      if (rst_n && char_valid && char_ready) begin
         rx_cnt  = rx_cnt + 1;
         rx_last = char_data;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic b);
      @(posedge clk); #2;
      dec_valid = 1'b1;
      dec_bit   = b;
      @(posedge clk); #2;
      dec_valid = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         int n;
         bit_no++;
         n = 12;
         if (stretch_every != 0 && (bit_no % stretch_every) == 0) n = 13;
         for (int k = 0; k < n; k++) push(v[i]);
      end
   endtask

   task automatic send_preamble(input int n);
      for (int i = 0; i < n; i++) send_byte(8'hAB);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(locked == 1'b0, "R8 locked", locked, 0);
      check(char_valid == 1'b0, "R8 char_valid", char_valid, 0);
      check(overflow == 1'b0, "R8 overflow", overflow, 0);
   endtask

   task automatic t_single_sync;
      // off-grid start: 7 idle samples
      for (int k = 0; k < 7; k++) push(1'b0);
      send_byte(8'h00);
      send_byte(8'hAB);
      send_byte(8'h00);
      send_byte(8'h3C);
      @(negedge clk);
      check(locked == 1'b0, "R3 single sync no lock", locked, 0);
   endtask

   task automatic t_lock;
      int c0;
      c0 = rx_cnt;
      send_preamble(16);
      @(negedge clk);
      check(locked == 1'b1, "R3 lock after preamble", locked, 1);
      check(rx_cnt == c0, "R4 sync bytes discarded", rx_cnt, c0);
   endtask

   task automatic t_data;
      int c0;
      c0 = rx_cnt;
      send_byte(8'h48);
      check(rx_cnt == c0 + 1 && rx_last == 8'h48, "R5 char H", rx_last, 8'h48);
      send_byte(8'hAB);
      @(negedge clk);
      check(rx_cnt == c0 + 1 && locked, "R4 mid-data sync skipped", rx_cnt, c0 + 1);
      send_byte(8'h69);
      check(rx_cnt == c0 + 2 && rx_last == 8'h69, "R5 char i", rx_last, 8'h69);
   endtask

   task automatic t_drop;
      int c0;
      c0 = rx_cnt;
      send_byte(8'hC5);
      @(negedge clk);
      check(locked == 1'b0, "R5 high byte drops lock", locked, 0);
      check(rx_cnt == c0, "R5 high byte not output", rx_cnt, c0);
      send_byte(8'h41);
      send_byte(8'h42);
      check(rx_cnt == c0, "R5 no output while unlocked", rx_cnt, c0);
   endtask

   task automatic t_drift;
      int c0;
      stretch_every = 4;   // bit length ~2% long, needs R2 correction
      send_preamble(16);
      @(negedge clk);
      check(locked == 1'b1, "R2 lock under drift", locked, 1);
      c0 = rx_cnt;
      send_byte(8'h55);
      check(rx_cnt == c0 + 1 && rx_last == 8'h55, "R2 drift char U", rx_last, 8'h55);
      send_byte(8'h2A);
      send_byte(8'h4F);
      check(rx_cnt == c0 + 3 && rx_last == 8'h4F, "R2 drift char O", rx_last, 8'h4F);
      check(rx_cnt == c0 + 3, "R1 one char per 8 bits", rx_cnt, c0 + 3);
      stretch_every = 0;
   endtask

   task automatic t_overflow;
      int c0;
      c0 = rx_cnt;
      @(posedge clk); #2 char_ready = 1'b0;
      send_byte(8'h41);
      @(negedge clk);
      check(char_valid == 1'b1 && char_data == 8'h41, "R6 held char", char_data, 8'h41);
      check(overflow == 1'b0, "R7 no overflow yet", overflow, 0);
      send_byte(8'h42);
      @(negedge clk);
      check(char_valid == 1'b1 && char_data == 8'h41, "R6 held data stable", char_data, 8'h41);
      check(overflow == 1'b1, "R7 overflow set", overflow, 1);
      @(posedge clk); #2 char_ready = 1'b1;
      repeat (2) @(negedge clk);
      check(rx_cnt == c0 + 1 && rx_last == 8'h41, "R6 accepted held char", rx_last, 8'h41);
      check(char_valid == 1'b0, "R6 valid falls", char_valid, 0);
      check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      t_reset();
      t_single_sync();
      t_lock();
      t_data();
      t_drop();
      t_drift();
      t_overflow();
      finish_run();
   end
endmodule